// File: doc/BRIEF.md
# Dual-Channel Transmit FIFO Controller

This block is the transmit half of a simple Ethernet-style MAC. The host fills one of two independent byte FIFOs through a 32-bit register port. A channel-select register picks the FIFO that data writes go to. Each channel has its own send-length register and its own start command. Once a start is accepted, the block streams that channel's bytes out on a byte-wide valid/ready interface and marks the final byte. It then empties the channel, clears its length and raises that channel's completion status bit.

The completion bits feed a level interrupt through an enable mask. Software clears the bits by writing 1 to them. A soft-reset bit in the control register returns the register state and both FIFOs to their idle condition. Line coding and the receive path lie outside the block.

Top module: `dual_tx_fifo_ctrl`

Register word addresses: 0 control (bit 0 transmit enable, bit 1 soft reset), 1 mode (8 bits, plain storage), 2 channel select, 3 data, 4/5 length for channel 0/1, 6/7 command for channel 0/1 (write bit 0 = start; read returns the FIFO fill in bytes), 8 interrupt enable, 9 interrupt status (bit c = channel c done). Any other address reads as 0. Read data appears on `rd_data` in the cycle after `rd_en`.

## Requirements
- R1: A write to the channel-select register (address 2) with value 0 or 1 selects that channel; any value of 2 or more selects channel 0.
- R2: A write to the data register (address 3) appends 4 bytes to the selected FIFO, bits 7:0 first and bits 31:24 last, and bytes leave the stream in the order they were appended.
- R3: A data write is discarded when the selected FIFO has fewer than 4 free bytes; the fill never exceeds FIFO_BYTES.
- R4: A length write (address 4 or 5) above FIFO_BYTES stores FIFO_BYTES; smaller values are stored as written.
- R5: A start command has no effect unless control bit 0 (transmit enable) is already set.
- R6: An accepted start sends exactly min(length, fill) bytes; when that minimum is 0 nothing is sent and no state changes.
- R7: After the last byte of a send is accepted, the channel's fill reads 0, its length reads 0 and its status bit (bit c of address 9) is set.
- R8: Writing the status register clears each status bit written as 1 and leaves the others unchanged.
- R9: `irq` is high exactly when (status AND enable) is nonzero, and it follows every status or enable change on the next clock.
- R10: A control write with bit 1 set clears control, mode, enable, status, channel select, both lengths and both FIFOs, aborts any send in progress, and then stores the written value with bit 1 cleared.
- R11: `tx_data` and `tx_last` hold steady while `tx_valid` is high and `tx_ready` is low; `tx_last` is set only on the final byte of a send.
- R12: A start command issued while a send is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Registered read data, valid one cycle after rd_en |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Marks the final byte of a send |
| tx_ready | input | 1 | Downstream accepts the byte |
| irq | output | 1 | Level interrupt |

## Verification
A corrupted read pointer or a mis-steered push shows up in the very first byte of the next send, which comes out wrong or in the wrong position. A wrong remaining count shows up within one send as a byte count that is off or as `tx_last` landing on the wrong byte. A missed flush or length clear becomes visible on the next fill or length read-back after completion. A wrong status or mask register changes `irq` on the clock after the offending write. The bench sweeps both channels, every word count up to one past capacity, and every length up to one past capacity, with the receiver both always ready and stalling.

// File: rtl/dual_tx_pkg.sv
package dual_tx_pkg;
  localparam int NCH = 2;
  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_MODE  = 4'd1;
  localparam logic [3:0] A_CHSEL = 4'd2;
  localparam logic [3:0] A_DATA  = 4'd3;
  localparam logic [3:0] A_LEN0  = 4'd4;
  localparam logic [3:0] A_LEN1  = 4'd5;
  localparam logic [3:0] A_CMD0  = 4'd6;
  localparam logic [3:0] A_CMD1  = 4'd7;
  localparam logic [3:0] A_IEN   = 4'd8;
  localparam logic [3:0] A_ISTA  = 4'd9;
  localparam int CTRL_TXEN_BIT = 0;
  localparam int CTRL_SRST_BIT = 1;
endpackage

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [31:0]                push_word,
  input  logic                       pop,
  output logic [7:0]                 rd_byte,
  output logic [$clog2(DEPTH):0]     fill
);
  localparam int WORDS = DEPTH / 4;
  localparam int BPW   = $clog2(DEPTH);
  localparam int WPW   = $clog2(WORDS);
  localparam int FW    = BPW + 1;

  logic [31:0]    mem [WORDS];
  logic [WPW-1:0] wptr_q;
  logic [BPW-1:0] rptr_q;
  logic [FW-1:0]  fill_q;

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
      fill_q <= '0;
    end else begin
      if (push) wptr_q <= wptr_q + 1'b1;
      if (pop)  rptr_q <= rptr_q + 1'b1;
      fill_q <= fill_q + (push ? FW'(4) : FW'(0)) - (pop ? FW'(1) : FW'(0));
    end
  end

  assign rd_byte = mem[rptr_q[BPW-1:2]][{rptr_q[1:0], 3'b000} +: 8];
  assign fill    = fill_q;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    fill_q <= FW'(DEPTH));
endmodule

// File: rtl/tx_stream_out.sv
module tx_stream_out #(
  parameter int LW = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 abort,
  input  logic                 start_req,
  input  logic                 start_ch,
  input  logic [LW-1:0]        start_len,
  input  logic [1:0][7:0]      byte_in,
  output logic [1:0]           pop_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 done_ch_o,
  output logic                 out_valid,
  output logic [7:0]           out_data,
  output logic                 out_last,
  input  logic                 out_ready
);
  logic          busy_q, ch_q;
  logic [LW-1:0] remain_q;

  logic advance, finishing, load;
  assign advance   = busy_q && (!out_valid || out_ready);
  assign finishing = out_valid && out_ready && out_last;
  assign load      = advance && !finishing && (remain_q != '0);

  always_comb begin
    pop_o = 2'b00;
    if (load && !abort) pop_o[ch_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy_q    <= 1'b0;
      ch_q      <= 1'b0;
      remain_q  <= '0;
      done_o    <= 1'b0;
      done_ch_o <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_req) begin
        busy_q   <= 1'b1;
        ch_q     <= start_ch;
        remain_q <= start_len;
      end
      if (advance) begin
        if (finishing) begin
          busy_q    <= 1'b0;
          out_valid <= 1'b0;
          out_last  <= 1'b0;
          done_o    <= 1'b1;
          done_ch_o <= ch_q;
        end else if (remain_q != '0) begin
          out_valid <= 1'b1;
          out_data  <= byte_in[ch_q];
          out_last  <= (remain_q == LW'(1));
          remain_q  <= remain_q - 1'b1;
        end else begin
          out_valid <= 1'b0;
        end
      end
    end
  end

  assign busy_o = busy_q;

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !abort) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

// File: rtl/dual_tx_fifo_ctrl.sv
module dual_tx_fifo_ctrl
  import dual_tx_pkg::*;
#(
  parameter int FIFO_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [3:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready,
  output logic        irq
);
  localparam int LW = $clog2(FIFO_BYTES) + 1;

  logic [7:0]          ctrl_q, mode_q;
  logic                chsel_q;
  logic [NCH-1:0][LW-1:0] len_q;
  logic [NCH-1:0]      ien_q, ista_q, ien_d, ista_d;
  logic                irq_q;

  logic [NCH-1:0][LW-1:0] fill_w, eff_len;
  logic [NCH-1:0][7:0]    byte_w;
  logic [NCH-1:0]         push_w, pop_w, flush_w;
  logic                   busy, tx_done, done_ch;
  logic                   soft_rst, data_wr, start_go, start_ch;

  assign soft_rst = wr_en && (wr_addr == A_CTRL) && wr_data[CTRL_SRST_BIT];
  assign data_wr  = wr_en && (wr_addr == A_DATA) && !soft_rst;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      assign push_w[c]  = data_wr && (chsel_q == c[0]) &&
                          (fill_w[c] <= LW'(FIFO_BYTES - 4));
      assign flush_w[c] = soft_rst || (tx_done && (done_ch == c[0]));
      assign eff_len[c] = (len_q[c] < fill_w[c]) ? len_q[c] : fill_w[c];

      tx_byte_fifo #(.DEPTH(FIFO_BYTES)) u_fifo (
        .clk(clk), .rst(rst), .flush(flush_w[c]),
        .push(push_w[c]), .push_word(wr_data),
        .pop(pop_w[c]), .rd_byte(byte_w[c]), .fill(fill_w[c]));

      always_ff @(posedge clk) begin
        if (rst || soft_rst) len_q[c] <= '0;
        else if (wr_en && (wr_addr == A_LEN0 + 4'(c)))
          len_q[c] <= (wr_data > 32'(FIFO_BYTES)) ? LW'(FIFO_BYTES) : wr_data[LW-1:0];
        else if (tx_done && (done_ch == c[0])) len_q[c] <= '0;
      end
    end
  endgenerate

  always_comb begin
    start_ch = (wr_addr == A_CMD1);
    start_go = wr_en && ((wr_addr == A_CMD0) || (wr_addr == A_CMD1)) &&
               wr_data[0] && ctrl_q[CTRL_TXEN_BIT] && !busy && !tx_done &&
               (eff_len[start_ch] != '0);
  end

  tx_stream_out #(.LW(LW)) u_out (
    .clk(clk), .rst(rst), .abort(soft_rst),
    .start_req(start_go), .start_ch(start_ch), .start_len(eff_len[start_ch]),
    .byte_in(byte_w), .pop_o(pop_w), .busy_o(busy),
    .done_o(tx_done), .done_ch_o(done_ch),
    .out_valid(tx_valid), .out_data(tx_data), .out_last(tx_last),
    .out_ready(tx_ready));

  always_comb begin
    ien_d  = ien_q;
    ista_d = ista_q;
    if (wr_en && wr_addr == A_IEN)  ien_d  = wr_data[NCH-1:0];
    if (wr_en && wr_addr == A_ISTA) ista_d = ista_q & ~wr_data[NCH-1:0];
    if (tx_done) ista_d[done_ch] = 1'b1;
    if (soft_rst) begin
      ien_d  = '0;
      ista_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      mode_q  <= '0;
      chsel_q <= 1'b0;
      ien_q   <= '0;
      ista_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      ien_q  <= ien_d;
      ista_q <= ista_d;
      irq_q  <= |(ien_d & ista_d);
      if (wr_en && wr_addr == A_CTRL)
        ctrl_q <= wr_data[7:0] & ~(8'd1 << CTRL_SRST_BIT);
      if (soft_rst) begin
        mode_q  <= '0;
        chsel_q <= 1'b0;
      end else begin
        if (wr_en && wr_addr == A_MODE)  mode_q  <= wr_data[7:0];
        if (wr_en && wr_addr == A_CHSEL) chsel_q <= (wr_data < 32'd2) ? wr_data[0] : 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      case (rd_addr)
        A_CTRL:  rd_data <= 32'(ctrl_q);
        A_MODE:  rd_data <= 32'(mode_q);
        A_CHSEL: rd_data <= 32'(chsel_q);
        A_LEN0:  rd_data <= 32'(len_q[0]);
        A_LEN1:  rd_data <= 32'(len_q[1]);
        A_CMD0:  rd_data <= 32'(fill_w[0]);
        A_CMD1:  rd_data <= 32'(fill_w[1]);
        A_IEN:   rd_data <= 32'(ien_q);
        A_ISTA:  rd_data <= 32'(ista_q);
        default: rd_data <= '0;
      endcase
    end
  end

  assign irq = irq_q;

  // R1
  chsel_map_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CHSEL && wr_data >= 32'd2) |=> (chsel_q == 1'b0));
  // R4
  len_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (len_q[0] <= LW'(FIFO_BYTES)) && (len_q[1] <= LW'(FIFO_BYTES)));
  // R5
  no_start_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[CTRL_TXEN_BIT] && !busy) |=> !busy);
  // R7
  done_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_done && !soft_rst) |=> (fill_w[$past(done_ch)] == '0 && ista_q[$past(done_ch)]));
  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(ista_q & ien_q));
endmodule

// File: tb/tb_dual_tx_fifo_ctrl.sv
module tb_dual_tx_fifo_ctrl;
  import dual_tx_pkg::*;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0, tx_ready = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic tx_valid, tx_last, irq;
  logic [7:0] tx_data;

  int tests = 0, fails = 0, cyc = 0;
  int ready_mode = 0;
  int rx_cnt = 0, last_cnt = 0, last_pos = -1;
  logic [7:0] rx_buf [64];

  always #5 clk = ~clk;

  dual_tx_fifo_ctrl #(.FIFO_BYTES(DEPTH)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .irq(irq));

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      #2 tx_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? (cyc % 3 != 0) : 1'b0;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (tx_valid && tx_ready) begin
        if (rx_cnt < 64) rx_buf[rx_cnt] = tx_data;
        if (tx_last) begin last_cnt++; last_pos = rx_cnt; end
        rx_cnt++;
      end
    end
  end

  initial begin
    wait (cyc > 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic clr_rx();
    rx_cnt = 0; last_cnt = 0; last_pos = -1;
  endtask

  function automatic logic [31:0] mkword(input int base, input int k);
    logic [31:0] w;
    for (int j = 0; j < 4; j++) w[8*j +: 8] = 8'((base + 4*k + j) & 255);
    return w;
  endfunction

  task automatic sweep_case(input int ch, input int nw, input int len, input int mode);
    logic [31:0] r;
    int base, exp, fill_exp, len_c, bad;
    base = (ch * 100 + len * 3 + nw) & 255;
    len_c = (len > DEPTH) ? DEPTH : len;
    fill_exp = (4 * nw > DEPTH) ? DEPTH : 4 * nw;
    exp = (len_c < fill_exp) ? len_c : fill_exp;
    wr(A_CTRL, 32'h3);
    wr(A_CHSEL, 32'(ch));
    for (int k = 0; k < nw; k++) wr(A_DATA, mkword(base, k));
    wr(ch ? A_LEN1 : A_LEN0, 32'(len));
    clr_rx(); ready_mode = mode;
    wr(ch ? A_CMD1 : A_CMD0, 32'h1);
    repeat (70) @(negedge clk);
    check("R6 byte count", rx_cnt, exp);
    bad = 0;
    for (int j = 0; j < exp && j < 64; j++)
      if (rx_buf[j] != 8'((base + j) & 255)) bad++;
    check("R2 byte order", bad, 0);
    check("R11 last count", last_cnt, exp ? 1 : 0);
    check("R11 last position", last_pos, exp - 1);
    rd(A_ISTA, r); check("R7 status bit", r, exp ? (1 << ch) : 0);
    rd(ch ? A_CMD1 : A_CMD0, r); check("R3 R7 fill after", r, exp ? 0 : fill_exp);
    rd(ch ? A_LEN1 : A_LEN0, r); check("R4 R7 length after", r, exp ? 0 : len_c);
  endtask

  initial begin
    logic [31:0] r;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state
    rd(A_CTRL, r);  check("R10 reset ctrl", r, 0);
    rd(A_ISTA, r);  check("R10 reset status", r, 0);
    rd(A_CMD0, r);  check("R10 reset fill", r, 0);
    check("R9 reset irq", irq, 0);
    check("R11 reset valid", tx_valid, 0);

    // R1 channel select mapping
    wr(A_CHSEL, 1); rd(A_CHSEL, r); check("R1 sel 1", r, 1);
    wr(A_CHSEL, 2); rd(A_CHSEL, r); check("R1 sel 2", r, 0);
    wr(A_CHSEL, 1); wr(A_CHSEL, 7); rd(A_CHSEL, r); check("R1 sel 7", r, 0);
    wr(A_CHSEL, 1); wr(A_CHSEL, 32'h8000_0001); rd(A_CHSEL, r); check("R1 sel big", r, 0);

    // R4 clamp
    wr(A_LEN1, 100); rd(A_LEN1, r); check("R4 clamp", r, DEPTH);
    wr(A_LEN1, 9);   rd(A_LEN1, r); check("R4 plain", r, 9);

    // R5 start without transmit enable
    wr(A_CTRL, 32'h2); wr(A_CHSEL, 0); wr(A_DATA, 32'h44332211); wr(A_LEN0, 4);
    clr_rx(); ready_mode = 0; wr(A_CMD0, 1);
    repeat (20) @(negedge clk);
    check("R5 no bytes", rx_cnt, 0);
    rd(A_CMD0, r); check("R5 fill kept", r, 4);
    rd(A_ISTA, r); check("R5 no status", r, 0);

    // R12 start ignored while busy, R11 hold under stall
    wr(A_CTRL, 32'h3);
    wr(A_CHSEL, 0); wr(A_DATA, 32'h03020100); wr(A_DATA, 32'h07060504);
    wr(A_CHSEL, 1); wr(A_DATA, 32'hA3A2A1A0);
    wr(A_LEN0, 8); wr(A_LEN1, 4);
    clr_rx(); ready_mode = 2; wr(A_CMD0, 1);
    repeat (4) @(negedge clk);
    check("R11 valid while stalled", tx_valid, 1);
    held = tx_data;
    wr(A_CMD1, 1);
    repeat (3) @(negedge clk);
    check("R11 data held", tx_data, held);
    check("R11 first byte", held, 8'h00);
    ready_mode = 0;
    repeat (40) @(negedge clk);
    check("R12 only channel 0 sent", rx_cnt, 8);
    rd(A_CMD1, r); check("R12 channel 1 untouched", r, 4);
    rd(A_ISTA, r); check("R12 status", r, 1);

    // R8 / R9 on both status bits
    clr_rx(); wr(A_CMD1, 1); repeat (20) @(negedge clk);
    check("R2 channel 1 bytes", rx_cnt, 4);
    check("R2 channel 1 last byte", rx_buf[3], 8'hA3);
    rd(A_ISTA, r); check("R7 both status", r, 3);
    check("R9 irq masked", irq, 0);
    wr(A_IEN, 2); check("R9 irq on bit1", irq, 1);
    wr(A_ISTA, 2); rd(A_ISTA, r); check("R8 w1c", r, 1);
    check("R9 irq off after clear", irq, 0);
    wr(A_ISTA, 0); rd(A_ISTA, r); check("R8 write zero keeps", r, 1);
    wr(A_IEN, 1); check("R9 irq on bit0", irq, 1);

    // R10 soft reset
    wr(A_MODE, 32'h5A); wr(A_CHSEL, 1); wr(A_DATA, 32'h1); wr(A_LEN1, 3);
    rd(A_MODE, r); check("R10 mode stored", r, 32'h5A);
    wr(A_CTRL, 32'h2);
    rd(A_CTRL, r);  check("R10 ctrl", r, 0);
    rd(A_MODE, r);  check("R10 mode", r, 0);
    rd(A_CHSEL, r); check("R10 chsel", r, 0);
    rd(A_IEN, r);   check("R10 enable", r, 0);
    rd(A_ISTA, r);  check("R10 status", r, 0);
    rd(A_CMD1, r);  check("R10 fill", r, 0);
    rd(A_LEN1, r);  check("R10 length", r, 0);
    check("R10 irq", irq, 0);
    wr(A_CTRL, 32'h83); rd(A_CTRL, r); check("R10 reset bit dropped", r, 32'h81);

    // sweep
    for (int ch = 0; ch < 2; ch++)
      for (int nw = 0; nw <= 5; nw++)
        for (int len = 0; len <= DEPTH + 1; len++)
          sweep_case(ch, nw, len, (len + nw) % 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule